// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-core countdown timer. Software loads a 32-bit initial count. The count then falls by one on every prescaled tick. When it reaches zero, the block raises a one-cycle interrupt request that carries an 8-bit vector.

A timer entry register holds three things: the vector, a mask flag and a mode flag. In one-shot mode the count stops at zero. In periodic mode it wraps back to the initial value, so each period is the initial count plus one ticks.

A divide register picks the prescale ratio, a power of two from 1 to 128. It uses a three-bit code spread over non-adjacent bits. A clock-enable input gates all counting, so the block can run from a slower time base derived from the core clock.

The three registers share one write-data bus, and each has its own write strobe. The current count is always visible on an output port. Delivery of the request into an interrupt priority unit is left to the surrounding logic.

Top module: `local_irq_timer`

## Requirements
- R1: After reset the current count reads 0, no request is raised, and the timer entry is masked with vector 0.
- R2: The divide register keeps write-data bits 0, 1 and 3; bit 2 is ignored. The code is {bit3, bit1, bit0} and the prescale shift is (code + 1) mod 8. Value 0x0 divides by 2, 0x8 divides by 32, 0xB divides by 1, and 0x4 behaves as 0x0.
- R3: A 7-bit prescale counter counts the cycles with the clock enable high. A load of the initial count clears it. A prescaled tick happens in an enabled cycle whose counter value has all of its low shift bits set. With the enable low, nothing changes.
- R4: A write of the initial count makes the current count equal to the written value in the next cycle and restarts the prescaler. This write takes precedence over a tick in the same cycle.
- R5: In one-shot mode (entry bit 17 = 0), each tick lowers a nonzero count by one. The count holds at zero once it gets there.
- R6: In periodic mode (entry bit 17 = 1), a tick at count zero reloads the initial count. The sequence therefore repeats every initial + 1 ticks.
- R7: The tick that moves the count from 1 to 0 raises irq_req for exactly one cycle, in the cycle in which the count first reads 0. irq_vec always shows entry bits 7:0. While entry bit 16 (mask) is set, no request is raised but counting goes on.
- R8: With an initial count of zero the timer does not run and never raises a request, in either mode.
- R9: A write to the timer entry re-evaluates whether the timer runs. Switching an expired one-shot timer to periodic resumes wrapping at the next tick. Switching back to one-shot stops it at the next zero.
- R10: In one-shot mode a single load raises at most one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Clock enable for the prescaler and counter |
| init_we | input | 1 | Write strobe for the initial count |
| div_we | input | 1 | Write strobe for the divide register |
| entry_we | input | 1 | Write strobe for the timer entry |
| wdata | input | 32 | Shared write data |
| cur_count | output | 32 | Current count |
| irq_req | output | 1 | One-cycle expiry request |
| irq_vec | output | 8 | Vector from the timer entry |

## Verification
Directed runs cover several cases: one-shot countdown with divide by 2; periodic wrap with divide by 1; divide by 32; and the divide value with only bit 2 set. Comparing these shows whether the non-adjacent code is decoded and whether the wrap period includes the extra tick. Further directed runs hold the enable low, mask the entry, load zero and switch modes after expiry. These tell apart a true freeze, suppressed delivery, a stopped timer and re-evaluation on an entry write. A long random run mixes all strobes with a sparse enable and short counts, and compares every cycle against a bench model. This catches ordering errors between a load, a divide change and a tick in the same cycle.

// File: rtl/lct_pkg.sv
package lct_pkg;

   localparam int DIV_CFG_W = 4;
   localparam int SHIFT_W   = 3;

   // Divider code {cfg[3], cfg[1:0]}; prescale shift = code + 1 (mod 8).
   function automatic logic [SHIFT_W-1:0] lct_decode_shift(input logic [DIV_CFG_W-1:0] cfg);
      logic [SHIFT_W-1:0] code;
      code = {cfg[3], cfg[1:0]};
      return code + SHIFT_W'(1);
   endfunction

   // Bits of the divide register that are kept on a write.
   localparam logic [DIV_CFG_W-1:0] DIV_KEEP = 4'b1011;

endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler #(
   parameter int SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic               restart,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);
   localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;
   localparam int PC_W      = MAX_SHIFT;

   logic [PC_W-1:0]    pc_q;
   logic [MAX_SHIFT:0] aligned;

   // One alignment detector per possible shift value.
   for (genvar s = 0; s <= MAX_SHIFT; s++) begin : g_align
      if (s == 0) begin : g_zero
         assign aligned[s] = 1'b1;
      end else begin : g_low
         assign aligned[s] = &pc_q[s-1:0];
      end
   end

   assign tick = tick_en & aligned[shift];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (restart) begin
         pc_q <= '0;
      end else if (tick_en) begin
         pc_q <= pc_q + PC_W'(1);
      end
   end

   // R3: with the enable low the prescale counter holds
   a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !restart) |=> (pc_q == $past(pc_q)));

   // R4: a load restarts the prescaler
   a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pc_q == '0));

endmodule

// File: rtl/lct_counter.sv
module lct_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   input  logic             periodic,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] init_q;
   logic             running;
   logic             advance;

   assign running = (init_q != '0) && (periodic || (cnt_q != '0));
   assign advance = step && running && !load;
   assign expire  = advance && (cnt_q == CNT_W'(1));
   assign count   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         init_q <= '0;
      end else if (load) begin
         cnt_q  <= load_val;
         init_q <= load_val;
      end else if (advance) begin
         if (cnt_q == '0) begin
            cnt_q <= init_q;
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   // R4: load value appears in the next cycle
   a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));

   // R5: one-shot count never rises without a load
   a_r5_oneshot_nonrising: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !periodic) |=> (cnt_q <= $past(cnt_q)));

   // R6: periodic wrap reloads the initial count
   a_r6_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (step && periodic && !load && cnt_q == '0 && init_q != '0) |=> (cnt_q == $past(init_q)));

   // R8: zero initial count keeps the timer idle
   a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (init_q == '0 && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/lct_entry.sv
module lct_entry #(
   parameter int LVT_W    = 32,
   parameter int VEC_W    = 8,
   parameter int MASK_BIT = 16,
   parameter int MODE_BIT = 17
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       div_we,
   input  logic                       entry_we,
   input  logic [LVT_W-1:0]           wdata,
   input  logic                       expire,
   output logic [lct_pkg::SHIFT_W-1:0] shift,
   output logic                       periodic,
   output logic [VEC_W-1:0]           vec,
   output logic                       irq
);
   import lct_pkg::*;

   logic [DIV_CFG_W-1:0] cfg_q;
   logic [LVT_W-1:0]     ent_q;
   logic                 irq_q;
   logic                 masked;

   localparam logic [LVT_W-1:0] ENT_RESET = LVT_W'(1) << MASK_BIT;

   assign masked   = ent_q[MASK_BIT];
   assign periodic = ent_q[MODE_BIT];
   assign vec      = ent_q[VEC_W-1:0];
   assign shift    = lct_decode_shift(cfg_q);
   assign irq      = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         ent_q <= ENT_RESET;
         irq_q <= 1'b0;
      end else begin
         irq_q <= expire && !masked;
         if (div_we) begin
            cfg_q <= wdata[DIV_CFG_W-1:0] & DIV_KEEP;
         end
         if (entry_we) begin
            ent_q <= wdata;
         end
      end
   end

   // R7: a request only follows an unmasked entry
   a_r7_unmasked_only: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> !$past(masked));

   // R7: the request is a single-cycle pulse
   a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   // R2: divide register bit 2 always reads back clear
   a_r2_bit2_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      div_we |=> (cfg_q[2] == 1'b0));

endmodule

// File: rtl/local_irq_timer.sv
module local_irq_timer #(
   parameter int CNT_W    = 32,
   parameter int VEC_W    = 8,
   parameter int MASK_BIT = 16,
   parameter int MODE_BIT = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             init_we,
   input  logic             div_we,
   input  logic             entry_we,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cur_count,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec
);
   import lct_pkg::*;

   if (CNT_W < 8 || CNT_W > 64) begin : g_bad_cnt_w
      $error("local_irq_timer: CNT_W out of range");
   end
   if (MASK_BIT >= CNT_W || MODE_BIT >= CNT_W || MASK_BIT == MODE_BIT) begin : g_bad_bits
      $error("local_irq_timer: entry flag bits invalid");
   end
   if (MASK_BIT < VEC_W || MODE_BIT < VEC_W) begin : g_bad_overlap
      $error("local_irq_timer: flag bits overlap the vector field");
   end

   logic [SHIFT_W-1:0] shift;
   logic               tick;
   logic               periodic;
   logic               expire;

   lct_prescaler #(.SHIFT_W(SHIFT_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .restart (init_we),
      .shift   (shift),
      .tick    (tick)
   );

   lct_counter #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (init_we),
      .load_val (wdata),
      .step     (tick),
      .periodic (periodic),
      .count    (cur_count),
      .expire   (expire)
   );

   lct_entry #(
      .LVT_W    (CNT_W),
      .VEC_W    (VEC_W),
      .MASK_BIT (MASK_BIT),
      .MODE_BIT (MODE_BIT)
   ) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_we   (div_we),
      .entry_we (entry_we),
      .wdata    (wdata),
      .expire   (expire),
      .shift    (shift),
      .periodic (periodic),
      .vec      (irq_vec),
      .irq      (irq_req)
   );

   // R7: a request coincides with the count reading zero
   a_r7_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (cur_count == '0));

   // R10: no request in the cycle right after a load
   a_r10_no_irq_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      init_we |=> !irq_req);

endmodule

// File: tb/test_local_irq_timer.sv
`timescale 1ns/1ps
module test_local_irq_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        d_tick = 1'b0;
   logic        d_init = 1'b0;
   logic        d_div = 1'b0;
   logic        d_ent = 1'b0;
   logic [31:0] d_wdata = '0;
   logic [31:0] cur_count;
   logic        irq_req;
   logic [7:0]  irq_vec;

   always #2 clk = ~clk;

   local_irq_timer i_local_irq_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (d_tick),
      .init_we  (d_init),
      .div_we   (d_div),
      .entry_we (d_ent),
      .wdata    (d_wdata),
      .cur_count(cur_count),
      .irq_req  (irq_req),
      .irq_vec  (irq_vec)
   );

   int n_chk = 0;
   int n_fail = 0;
   int pulses = 0;
   bit done = 1'b0;

   // reference model state
   logic [31:0] m_cnt = '0;
   logic [31:0] m_init = '0;
   logic [6:0]  m_pc = '0;
   logic [3:0]  m_cfg = '0;
   logic [31:0] m_ent = 32'h0001_0000;
   logic        m_irq = 1'b0;

   function automatic int shift_of(input logic [3:0] cfg);
      return ({cfg[3], cfg[1:0]} + 1) % 8;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_edge();
      int          sh;
      logic [6:0]  msk;
      bit          run;
      bit          tk;
      logic        nirq;
      sh   = shift_of(m_cfg);
      msk  = 7'((1 << sh) - 1);
      run  = (m_init != 0) && (m_ent[17] || m_cnt != 0);
      tk   = d_tick && run && ((m_pc & msk) == msk);
      nirq = 1'b0;
      if (d_init) begin
         m_cnt  = d_wdata;
         m_init = d_wdata;
         m_pc   = '0;
      end else begin
         if (tk) begin
            if (m_cnt == 0) m_cnt = m_init;
            else begin
               if (m_cnt == 1 && !m_ent[16]) nirq = 1'b1;
               m_cnt = m_cnt - 1;
            end
         end
         if (d_tick) m_pc = m_pc + 7'd1;
      end
      if (d_div) m_cfg = d_wdata[3:0] & 4'hB;
      if (d_ent) m_ent = d_wdata;
      m_irq = nirq;
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      if (irq_req) pulses++;
      check(cur_count == m_cnt, tag, "count", cur_count, m_cnt);
      check(irq_req == m_irq, "R7", "irq_req", irq_req, m_irq);
      check(irq_vec == m_ent[7:0], "R7", "irq_vec", irq_vec, m_ent[7:0]);
   endtask

   task automatic wr(input int kind, input logic [31:0] d, input string tag);
      d_wdata = d;
      d_init = (kind == 0);
      d_div  = (kind == 1);
      d_ent  = (kind == 2);
      step(tag);
      d_init = 1'b0;
      d_div  = 1'b0;
      d_ent  = 1'b0;
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check(cur_count == 0, "R1", "count", cur_count, 0);
      check(irq_req == 0, "R1", "irq_req", irq_req, 0);
      check(irq_vec == 0, "R1", "irq_vec", irq_vec, 0);
      d_tick = 1'b1;

      // R5: one-shot with divide by 2 (reset divide value)
      wr(2, 32'h0000_0041, "R5");
      wr(0, 32'd5, "R4");
      check(cur_count == 5, "R4", "load", cur_count, 5);
      run(16, "R5");

      // R6: periodic with divide by 1
      wr(1, 32'h0000_000B, "R2");
      wr(2, 32'h0002_0033, "R6");
      wr(0, 32'd4, "R6");
      pulses = 0;
      run(15, "R6");
      check(pulses == 3, "R6", "pulses in 15 ticks", pulses, 3);

      // R2: bit 2 only acts as divide by 2; 0x8 divides by 32
      wr(1, 32'h0000_0004, "R2");
      wr(0, 32'd6, "R2");
      run(20, "R2");
      wr(1, 32'h0000_0008, "R2");
      wr(0, 32'd3, "R2");
      run(140, "R2");

      // R3: enable low freezes counting
      wr(1, 32'h0000_000B, "R3");
      wr(0, 32'd10, "R3");
      d_tick = 1'b0;
      run(10, "R3");
      check(cur_count == 10, "R3", "frozen", cur_count, 10);
      d_tick = 1'b1;
      run(3, "R3");

      // R7: masked periodic entry counts but raises nothing
      wr(2, 32'h0003_0077, "R7");
      wr(0, 32'd2, "R7");
      pulses = 0;
      run(10, "R7");
      check(pulses == 0, "R7", "masked pulses", pulses, 0);

      // R8: zero initial count, periodic, unmasked
      wr(2, 32'h0002_0011, "R8");
      wr(0, 32'd0, "R8");
      pulses = 0;
      run(10, "R8");
      check(pulses == 0, "R8", "pulses", pulses, 0);

      // R10: one-shot fires once per load
      wr(2, 32'h0000_0022, "R10");
      wr(0, 32'd3, "R10");
      pulses = 0;
      run(20, "R10");
      check(pulses == 1, "R10", "pulses", pulses, 1);

      // R9: switch expired one-shot to periodic, then back
      pulses = 0;
      wr(2, 32'h0002_0022, "R9");
      run(9, "R9");
      check(pulses == 2, "R9", "resumed pulses", pulses, 2);
      wr(2, 32'h0000_0022, "R9");
      run(6, "R9");
      check(cur_count == 0, "R9", "stopped", cur_count, 0);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         d_tick  = ($urandom % 4) != 0;
         d_wdata = '0;
         d_init  = ($urandom % 16) == 0;
         d_div   = ($urandom % 24) == 0;
         d_ent   = ($urandom % 20) == 0;
         if (d_init) d_wdata = $urandom % 48;
         else if (d_div) d_wdata = $urandom % 16;
         else if (d_ent) d_wdata = {14'd0, 1'($urandom % 2), 1'(($urandom % 4) == 0),
                                    8'd0, 8'($urandom)};
         step(m_ent[17] ? "R6" : "R5");
      end
      d_init = 1'b0;
      d_div  = 1'b0;
      d_ent  = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule